// File: doc/BRIEF.md
# Two-Level Paged Address Translator

This block turns 32-bit logical addresses into physical addresses for 4 KB pages. Each request first looks in a small fully associative translation cache, keyed on the 20-bit page number. On a hit the frame number comes straight from the cache and no memory traffic is generated. On a miss a hardware walker fetches two page-table words, one at a time, over a word-read port. The first word comes from the outer table, which a base register locates. The second comes from the inner table that the first word points to. The walker writes the resulting frame into the cache and returns the physical address. If a table entry is invalid, or the outer index lies outside the table length, it returns a fault instead.

The logical address splits into three fields: the outer index in bits [31:22], the inner index in bits [21:12] and the page offset in bits [11:0]. The offset passes through to the physical address unchanged. A single-cycle flush pulse empties the cache, for example after the tables are rewritten.

Top module: `pgx_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `rsp_fault` and `mem_req` are 0, and the cache holds no translation, so the first access to any page performs a table walk.
- R2: On a miss, the first memory read goes to `ptbr + vaddr[31:22]*4`.
- R3: The second read goes to `{outer[31:12], 12'h000} + vaddr[21:12]*4`, where `outer` is the word returned by the first read.
- R4: A successful walk returns `rsp_paddr = {inner[31:12], vaddr[11:0]}` with `rsp_fault` = 0. The response is visible 3 cycles after the accepting edge when each memory read is answered in the cycle after it is issued.
- R5: A request whose page number is cached produces its response in the cycle right after acceptance, with no memory read.
- R6: An outer entry with bit 0 equal to 0 ends the walk with `rsp_fault` = 1 and no second read.
- R7: An inner entry with bit 0 equal to 0 ends the walk with `rsp_fault` = 1.
- R8: A request whose outer index is greater than or equal to `ptlr` faults one cycle after acceptance. It issues no memory read, whatever the cache holds.
- R9: A one-cycle `flush` pulse invalidates every cached translation, so the next access to a previously cached page walks again.
- R10: The cache holds 8 translations and replaces them in round-robin order. After 9 distinct pages are filled, the first page misses and the other 8 still hit.
- R11: At most one memory read is outstanding. `mem_req` stays low until the pending read is answered, and `req_ready` stays low for the whole walk.
- R12: A faulting translation is never cached. Repeating the request walks and faults again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| ptbr | input | 32 | Byte address of the outer page table |
| ptlr | input | 11 | Number of legal outer-table entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation is illegal |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Byte address of the table word to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table word: frame in [31:12], valid in bit 0 |

## Verification
Each response has a latency counted in edges after the accepting clock edge. A hit responds at that same edge. A length fault responds 1 edge later. An invalid outer entry responds after 2 edges, and a full walk or an invalid inner entry after 3 edges, plus the memory latency of each read. The bench drives requests on falling edges, counts falling edges until `rsp_valid` appears and compares that count with the expected latency for the case. Each table read is logged at the falling edge where `mem_req` is seen, so every check of an address or a read count refers to a registered output that is already stable. A separate run with two extra cycles of memory latency checks that the response is delayed by exactly those cycles and that no second read overlaps a pending one.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_OUTER,
    WK_INNER,
    WK_FILL,
    WK_FAULT
  } walk_state_t;
endpackage

// File: rtl/pgx_tcache.sv
module pgx_tcache #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   ptr_q;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[ptr_q] <= wr_vpn;
      pfn_q[ptr_q] <= wr_pfn;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit); // R9
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
  import pgx_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2*IDX_W+OFF_W-1:0]   ptbr,
  input  logic [IDX_W:0]             ptlr,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]   req_vaddr,
  output logic                       rsp_valid,
  output logic [2*IDX_W+OFF_W-1:0]   rsp_paddr,
  output logic                       rsp_fault,
  output logic                       mem_req,
  output logic [2*IDX_W+OFF_W-1:0]   mem_addr,
  input  logic                       mem_rvalid,
  input  logic [2*IDX_W+OFF_W-1:0]   mem_rdata,
  output logic [2*IDX_W-1:0]         lk_vpn,
  input  logic                       lk_hit,
  input  logic [2*IDX_W-1:0]         lk_pfn,
  output logic                       wr_en,
  output logic [2*IDX_W-1:0]         wr_vpn,
  output logic [2*IDX_W-1:0]         wr_pfn
);
  localparam int ADDR_W = 2 * IDX_W + OFF_W;
  localparam int VPN_W  = 2 * IDX_W;

  walk_state_t state_q;
  logic [ADDR_W-1:0] va_q;
  logic [VPN_W-1:0]  pfn_q;

  logic [IDX_W-1:0] in_outer;
  logic [IDX_W-1:0] q_inner;
  logic             len_ok;
  logic             accept;

  assign in_outer  = req_vaddr[ADDR_W-1 -: IDX_W];
  assign q_inner   = va_q[OFF_W +: IDX_W];
  assign len_ok    = {1'b0, in_outer} < ptlr;
  assign req_ready = (state_q == WK_IDLE);
  assign accept    = req_valid && req_ready;
  assign lk_vpn    = req_vaddr[ADDR_W-1:OFF_W];
  assign wr_en     = (state_q == WK_FILL);
  assign wr_vpn    = va_q[ADDR_W-1:OFF_W];
  assign wr_pfn    = pfn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WK_IDLE;
      va_q      <= '0;
      pfn_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_req   <= 1'b0;
      unique case (state_q)
        WK_IDLE: begin
          if (req_valid) begin
            va_q <= req_vaddr;
            if (!len_ok) begin
              state_q <= WK_FAULT;
            end else if (lk_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= {lk_pfn, req_vaddr[OFF_W-1:0]};
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= ptbr + ADDR_W'({in_outer, 2'b00});
              state_q  <= WK_OUTER;
            end
          end
        end
        WK_OUTER: begin
          if (mem_rvalid) begin
            if (!mem_rdata[0]) begin
              state_q <= WK_FAULT;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= {mem_rdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                          + ADDR_W'({q_inner, 2'b00});
              state_q  <= WK_INNER;
            end
          end
        end
        WK_INNER: begin
          if (mem_rvalid) begin
            if (!mem_rdata[0]) begin
              state_q <= WK_FAULT;
            end else begin
              pfn_q   <= mem_rdata[ADDR_W-1:OFF_W];
              state_q <= WK_FILL;
            end
          end
        end
        WK_FILL: begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_paddr <= {pfn_q, va_q[OFF_W-1:0]};
          state_q   <= WK_IDLE;
        end
        WK_FAULT: begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
          rsp_paddr <= '0;
          state_q   <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  AST_HIT_FAST: assert property (@(posedge clk) disable iff (rst)
    accept && lk_hit && len_ok |=> rsp_valid && !rsp_fault && !mem_req); // R5
  AST_LEN_FAULT: assert property (@(posedge clk) disable iff (rst)
    accept && !len_ok |=> !mem_req ##1 (rsp_valid && rsp_fault)); // R8
  AST_OUTER_INVALID: assert property (@(posedge clk) disable iff (rst)
    (state_q == WK_OUTER) && mem_rvalid && !mem_rdata[0]
      |=> !mem_req ##1 (rsp_valid && rsp_fault)); // R6
  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rvalid |=> !mem_req); // R11
  AST_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept && !(lk_hit && len_ok) |=> !req_ready); // R11
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate #(
  parameter int IDX_W      = 10,
  parameter int OFF_W      = 12,
  parameter int TC_ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [2*IDX_W+OFF_W-1:0] ptbr,
  input  logic [IDX_W:0]           ptlr,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  output logic                     rsp_valid,
  output logic [2*IDX_W+OFF_W-1:0] rsp_paddr,
  output logic                     rsp_fault,
  output logic                     mem_req,
  output logic [2*IDX_W+OFF_W-1:0] mem_addr,
  input  logic                     mem_rvalid,
  input  logic [2*IDX_W+OFF_W-1:0] mem_rdata
);
  localparam int VPN_W = 2 * IDX_W;

  logic [VPN_W-1:0] lk_vpn, lk_pfn, wr_vpn, wr_pfn;
  logic             lk_hit, wr_en;

  pgx_tcache #(
    .VPN_W  (VPN_W),
    .PFN_W  (VPN_W),
    .ENTRIES(TC_ENTRIES)
  ) u_cache (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .lk_vpn(lk_vpn),
    .lk_hit(lk_hit),
    .lk_pfn(lk_pfn),
    .wr_en (wr_en),
    .wr_vpn(wr_vpn),
    .wr_pfn(wr_pfn)
  );

  pgx_walker #(
    .IDX_W(IDX_W),
    .OFF_W(OFF_W)
  ) u_walk (
    .clk       (clk),
    .rst       (rst),
    .ptbr      (ptbr),
    .ptlr      (ptlr),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .lk_vpn    (lk_vpn),
    .lk_hit    (lk_hit),
    .lk_pfn    (lk_pfn),
    .wr_en     (wr_en),
    .wr_vpn    (wr_vpn),
    .wr_pfn    (wr_pfn)
  );
endmodule

// File: tb/tb_pgx_xlate.sv
module tb_pgx_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [31:0] ptbr = 32'h0001_0000;
  logic [10:0] ptlr = 11'd4;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  pgx_xlate dut (
    .clk(clk), .rst(rst), .flush(flush), .ptbr(ptbr), .ptlr(ptlr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  // memory model: table words, latency, read log
  logic [31:0] pmem [logic [31:0]];
  logic [31:0] rlog [256];
  int          reads = 0;
  int          overlap = 0;
  int          mem_lat = 0;
  logic        pend = 1'b0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_word(pend_addr);
        pend       = 1'b0;
      end else begin
        pend_cnt--;
      end
    end
    if (mem_req) begin
      if (pend) overlap++;
      rlog[reads[7:0]] = mem_addr;
      reads++;
      if (mem_lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_word(mem_addr);
      end else begin
        pend      = 1'b1;
        pend_cnt  = mem_lat - 1;
        pend_addr = mem_addr;
      end
    end
  end

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                       output logic flt, output int lat, output int nrd,
                       output int first_rd, output logic busy_rdy);
    @(negedge clk);
    first_rd  = reads;
    req_valid = 1'b1;
    req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    busy_rdy = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_rdy = 1'b1;
      @(negedge clk);
      lat++;
    end
    pa  = rsp_paddr;
    flt = rsp_fault;
    nrd = reads - first_rd;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic        flt;
    logic [3:0]  nrd;
    logic [3:0]  lat;
    logic [31:0] a0;
    logic [31:0] a1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1123, 32'h0010_1123, 1'b0, 4'd2, 4'd3, 32'h0001_0000, 32'h0002_0004},
    '{32'h0000_1FFF, 32'h0010_1FFF, 1'b0, 4'd0, 4'd0, 32'h0, 32'h0},
    '{32'h00C0_7000, 32'hABCD_E000, 1'b0, 4'd2, 4'd3, 32'h0001_000C, 32'h0003_001C},
    '{32'h0040_0000, 32'h0,         1'b1, 4'd1, 4'd2, 32'h0001_0004, 32'h0},
    '{32'h0000_5ABC, 32'h0,         1'b1, 4'd2, 4'd3, 32'h0001_0000, 32'h0002_0014},
    '{32'h0100_0000, 32'h0,         1'b1, 4'd0, 4'd1, 32'h0, 32'h0},
    '{32'h0000_5ABC, 32'h0,         1'b1, 4'd2, 4'd3, 32'h0001_0000, 32'h0002_0014},
    '{32'h00C0_7456, 32'hABCD_E456, 1'b0, 4'd0, 4'd0, 32'h0, 32'h0}
  };
  localparam string VTAG [NV] = '{"R4", "R5", "R3", "R6", "R7", "R8", "R12", "R5"};

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    logic        flt, brdy;
    int          lat, nrd, f0;

    pmem[32'h0001_0000] = 32'h0002_0001;
    pmem[32'h0001_0004] = 32'h0000_0000;
    pmem[32'h0001_000C] = 32'h0003_0001;
    for (int k = 0; k < 16; k++)
      pmem[32'h0002_0000 + 32'(k * 4)] = (k == 5) ? 32'h0 : ((32'h100 + 32'(k)) << 12) | 32'h1;
    pmem[32'h0003_001C] = 32'hABCD_E001;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check32("R1", "req_ready", 32'(req_ready), 32'h1);
    check32("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
    check32("R1", "rsp_fault", 32'(rsp_fault), 32'h0);
    check32("R1", "mem_req",   32'(mem_req),   32'h0);

    for (int i = 0; i < NV; i++) begin
      xlate(VEC[i].va, pa, flt, lat, nrd, f0, brdy);
      check32(VTAG[i], "fault", 32'(flt), 32'(VEC[i].flt));
      check32(VTAG[i], "reads", 32'(nrd), 32'(VEC[i].nrd));
      check32(VTAG[i], "latency", 32'(lat), 32'(VEC[i].lat));
      if (!VEC[i].flt) check32(VTAG[i], "paddr", pa, VEC[i].pa);
      if (VEC[i].nrd >= 1) check32("R2", "outer addr", rlog[f0[7:0]], VEC[i].a0);
      if (VEC[i].nrd >= 2) check32("R3", "inner addr", rlog[8'(f0 + 1)], VEC[i].a1);
    end

    // R9: flush forces a walk for a page that was cached
    pulse_flush();
    xlate(32'h0000_1000, pa, flt, lat, nrd, f0, brdy);
    check32("R9", "reads after flush", 32'(nrd), 32'h2);
    check32("R9", "paddr after flush", pa, 32'h0010_1000);

    // R10: 9 distinct pages into 8 slots, round robin
    pulse_flush();
    begin
      int pg [9] = '{0, 1, 2, 3, 4, 6, 7, 8, 9};
      for (int j = 0; j < 9; j++) begin
        xlate(32'(pg[j]) << 12, pa, flt, lat, nrd, f0, brdy);
        check32("R10", "fill reads", 32'(nrd), 32'h2);
      end
      xlate(32'(pg[0]) << 12, pa, flt, lat, nrd, f0, brdy);
      check32("R10", "evicted page reads", 32'(nrd), 32'h2);
      for (int j = 2; j < 9; j++) begin
        xlate((32'(pg[j]) << 12) | 32'h0AB, pa, flt, lat, nrd, f0, brdy);
        check32("R10", "kept page reads", 32'(nrd), 32'h0);
        check32("R10", "kept page paddr", pa, ((32'h100 + 32'(pg[j])) << 12) | 32'h0AB);
      end
    end

    // R11: slow memory, single outstanding read, busy while walking
    mem_lat = 2;
    pulse_flush();
    xlate(32'h00C0_7321, pa, flt, lat, nrd, f0, brdy);
    check32("R11", "slow latency", 32'(lat), 32'd7);
    check32("R11", "overlapping reads", 32'(overlap), 32'h0);
    check32("R11", "ready during walk", 32'(brdy), 32'h0);
    check32("R11", "slow paddr", pa, 32'hABCD_E321);
    mem_lat = 0;

    // R8: length fault even when the page is cached
    ptlr = 11'd3;
    xlate(32'h00C0_7000, pa, flt, lat, nrd, f0, brdy);
    check32("R8", "cached but out of length fault", 32'(flt), 32'h1);
    check32("R8", "no reads", 32'(nrd), 32'h0);
    ptlr = 11'd4;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule